// File: doc/BRIEF.md
# I2C Serial EEPROM Write Target

This block is the write side of a 128-byte serial EEPROM that answers on an I2C bus. It watches SCL and SDA, both already synchronized to the system clock. It finds START and STOP conditions and decodes the device select byte against a 3-bit strap. It then takes a byte address and one or more data bytes. Acknowledges go out on an open-drain enable, which pulls SDA low while it is high. Accepted data is held in an 8-slot staging buffer and moves into the storage array only when a STOP arrives.

Two inputs shape each transfer. A write-control input blocks the transfer if it is high at any point from START until the byte address has been taken. A blocked transfer still acknowledges the select and address bytes, but it refuses every data byte and changes nothing. A burst-mode input, latched when the byte address completes, picks how a burst is placed. In multibyte mode, up to four bytes go to consecutive addresses. In page mode, bytes fill an 8-byte page, and the slot pointer wraps inside that page. A single-byte write gives the same result in either mode. A combinational observation port exposes any array location.

Top module: `sereep_wr_ctrl`

## Requirements
- R1: The select byte is acknowledged only when its bits 7:4 are 1010, bits 3:1 equal `strap_i` and bit 0 (RW) is 0. Any other select byte is not acknowledged, and no later byte is acknowledged until the next START.
- R2: After a matching select byte, the byte address is always acknowledged. Its bit 7 is ignored and bits 6:0 pick the location.
- R3: If `wc_i` is high in any cycle from START through the end of the address byte, every data byte is left unacknowledged and no array location changes. A high `wc_i` only during data bytes has no effect.
- R4: A single data byte followed by STOP is acknowledged and lands at the addressed location, with the same result for both levels of `burst_mode_i`.
- R5: With `burst_mode_i`=1 latched, the first four data bytes are acknowledged and go to the start address plus 0..3, modulo 128. Further bytes are not acknowledged and are dropped.
- R6: With `burst_mode_i`=0 latched, every data byte is acknowledged. Byte k goes to the location whose bits 6:3 come from the start address and whose bits 2:0 are (start bits 2:0 + k) mod 8. A later byte to the same location replaces an earlier one.
- R7: No array location changes before STOP. A repeated START in mid-transfer discards all staged bytes.
- R8: `sda_oe_o` rises only on the SCL falling edge after a byte's eighth bit, and falls on the next SCL falling edge. It changes only while SCL is low, and it is low after any START or STOP.
- R9: After reset, `sda_oe_o` is low and every array location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level |
| wc_i | input | 1 | Write-control (1 = block data) |
| burst_mode_i | input | 1 | 1 = multibyte burst, 0 = page burst |
| strap_i | input | 3 | Chip-address strap |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| peek_addr_i | input | 7 | Array observation address |
| peek_data_o | output | 8 | Array contents at `peek_addr_i` |

## Verification
The bench sweeps all eight strap values and also tries a read select and a wrong device type. A faulty decoder would acknowledge a foreign or read select, or keep answering after a refusal. Write-control is raised in three places: only during the select byte, only during the address byte, and only during the data bytes. A design that sampled it at one instant would write in the first two cases, and a design that sampled it too long would block the third. Bursts start at 0x7E in multibyte mode and at 0x13 with ten bytes in page mode. These catch a missing 128-address wrap, a missing fourth-byte cap, and page wrap or overwrite order that leaks into the next page. The array is compared in full before a STOP and after a repeated START, which exposes any early commit or any staged data that survives.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
  typedef enum logic [1:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_DATA} wr_st_e;
endpackage

// File: rtl/i2cw_bus_cond.sv
module i2cw_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cw_byte_rx.sv
module i2cw_byte_rx
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_i,
  input  logic              restart,
  input  logic              ack_req,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_oe
);
  localparam int PH_W = $clog2(BYTE_W + 2);
  localparam logic [PH_W-1:0] PH_ACK  = PH_W'(BYTE_W);
  localparam logic [PH_W-1:0] PH_HOLD = PH_W'(BYTE_W + 1);

  logic [PH_W-1:0]   ph_q, ph_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;

  always_comb begin
    ph_d      = ph_q;
    sh_d      = sh_q;
    oe_d      = oe_q;
    byte_done = 1'b0;
    if (restart) begin
      ph_d = '0;
      oe_d = 1'b0;
    end else if (scl_rise && (ph_q < PH_ACK)) begin
      sh_d = {sh_q[BYTE_W-2:0], sda_i};
      ph_d = ph_q + 1'b1;
    end else if (scl_fall && (ph_q == PH_ACK)) begin
      byte_done = 1'b1;
      oe_d      = ack_req;
      ph_d      = PH_HOLD;
    end else if (scl_fall && (ph_q == PH_HOLD)) begin
      oe_d = 1'b0;
      ph_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign rx_byte = sh_q;
  assign sda_oe  = oe_q;
endmodule

// File: rtl/i2cw_array.sv
module i2cw_array #(
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int SLOTS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [SLOTS-1:0]          slot_vld,
  input  logic [SLOTS-1:0][AW-1:0]  slot_addr,
  input  logic [SLOTS-1:0][DW-1:0]  slot_data,
  input  logic [AW-1:0]             peek_addr,
  output logic [DW-1:0]             peek_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic          hit;
    logic [DW-1:0] wd;
    always_comb begin
      hit = 1'b0;
      wd  = mem_q[e];
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_vld[s] && (slot_addr[s] == AW'(e))) begin
          hit = 1'b1;
          wd  = slot_data[s];
        end
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[e] <= '0;
      else if (commit && hit) mem_q[e] <= wd;
    end
  end

  assign peek_data = mem_q[peek_addr];
endmodule

// File: rtl/sereep_wr_ctrl.sv
module sereep_wr_ctrl
  import i2cw_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int STRAP_W   = 3,
  parameter int PAGE_SLOTS = 8,
  parameter int BURST_MAX = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                wc_i,
  input  logic                burst_mode_i,
  input  logic [STRAP_W-1:0]  strap_i,
  output logic                sda_oe_o,
  input  logic [ADDR_W-1:0]   peek_addr_i,
  output logic [BYTE_W-1:0]   peek_data_o
);
  localparam int SLOT_W = $clog2(PAGE_SLOTS);
  localparam int CNT_W  = $clog2(BURST_MAX + 1);

  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, ack_req, commit;
  logic [BYTE_W-1:0] rx_byte;

  i2cw_bus_cond u_cond (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_byte_rx u_rx (
    .clk(clk), .rst_n(rst_sn), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_i(sda_i), .restart(start_det | stop_det), .ack_req(ack_req),
    .byte_done(byte_done), .rx_byte(rx_byte), .sda_oe(sda_oe_o)
  );

  wr_st_e                           st_q, st_d;
  logic                             wp_q, wp_d;
  logic                             mb_q, mb_d;
  logic [ADDR_W-1:0]                base_q, base_d;
  logic [SLOT_W-1:0]                ptr_q, ptr_d;
  logic [CNT_W-1:0]                 cnt_q, cnt_d;
  logic [PAGE_SLOTS-1:0]            vld_q, vld_d;
  logic [PAGE_SLOTS-1:0][ADDR_W-1:0] sa_q, sa_d;
  logic [PAGE_SLOTS-1:0][BYTE_W-1:0] sd_q, sd_d;
  logic                             sel_match;
  logic [SLOT_W-1:0]                slot_idx;
  logic [ADDR_W-1:0]                slot_adr;

  assign sel_match = (rx_byte[7:4] == DEV_TYPE) &&
                     (rx_byte[STRAP_W:1] == strap_i) && !rx_byte[0];

  always_comb begin
    if (mb_q) begin
      slot_idx = SLOT_W'(cnt_q);
      slot_adr = base_q + ADDR_W'(cnt_q);
    end else begin
      slot_idx = ptr_q;
      slot_adr = {base_q[ADDR_W-1:SLOT_W], ptr_q};
    end
  end

  always_comb begin
    st_d = st_q;  wp_d = wp_q;  mb_d = mb_q;  base_d = base_q;
    ptr_d = ptr_q;  cnt_d = cnt_q;  vld_d = vld_q;  sa_d = sa_q;  sd_d = sd_q;
    ack_req = 1'b0;
    commit  = 1'b0;
    if (start_det) begin
      st_d  = ST_DEV;
      wp_d  = wc_i;
      vld_d = '0;
      cnt_d = '0;
    end else if (stop_det) begin
      commit = (st_q == ST_DATA) && !wp_q;
      st_d   = ST_IDLE;
      vld_d  = '0;
    end else begin
      case (st_q)
        ST_DEV: begin
          wp_d    = wp_q | wc_i;
          ack_req = sel_match;
          if (byte_done) st_d = sel_match ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          wp_d    = wp_q | wc_i;
          ack_req = 1'b1;
          if (byte_done) begin
            base_d = rx_byte[ADDR_W-1:0];
            ptr_d  = rx_byte[SLOT_W-1:0];
            mb_d   = burst_mode_i;
            st_d   = ST_DATA;
          end
        end
        ST_DATA: begin
          ack_req = !wp_q && (!mb_q || (cnt_q < CNT_W'(BURST_MAX)));
          if (byte_done && ack_req) begin
            sd_d[slot_idx]  = rx_byte;
            sa_d[slot_idx]  = slot_adr;
            vld_d[slot_idx] = 1'b1;
            ptr_d = ptr_q + 1'b1;
            if (mb_q) cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= ST_IDLE;  wp_q <= 1'b0;  mb_q <= 1'b0;  base_q <= '0;
      ptr_q <= '0;  cnt_q <= '0;  vld_q <= '0;  sa_q <= '0;  sd_q <= '0;
    end else begin
      st_q <= st_d;  wp_q <= wp_d;  mb_q <= mb_d;  base_q <= base_d;
      ptr_q <= ptr_d;  cnt_q <= cnt_d;  vld_q <= vld_d;  sa_q <= sa_d;  sd_q <= sd_d;
    end
  end

  i2cw_array #(.AW(ADDR_W), .DW(BYTE_W), .SLOTS(PAGE_SLOTS)) u_array (
    .clk(clk), .rst_n(rst_sn), .commit(commit), .slot_vld(vld_q),
    .slot_addr(sa_q), .slot_data(sd_q),
    .peek_addr(peek_addr_i), .peek_data(peek_data_o)
  );
endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk #(
  parameter int CNT_W = 3,
  parameter int CAP   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_i,
  input logic             sda_oe_o,
  input logic             wp_q,
  input logic             commit,
  input logic [CNT_W-1:0] cnt_q
);
  // R8: the acknowledge enable only moves while SCL is low
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  // R8: a START releases SDA
  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $fell(sda_i)) |=> !sda_oe_o);

  // R8: a STOP releases SDA
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $rose(sda_i)) |=> !sda_oe_o);

  // R3: a protected transfer never commits
  p_wp_no_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wp_q);

  // R5: the multibyte count never passes its cap
  p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CAP));
endmodule

bind sereep_wr_ctrl i2cw_chk #(.CNT_W(CNT_W), .CAP(BURST_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe_o(sda_oe_o), .wp_q(wp_q), .commit(commit), .cnt_q(cnt_q)
);

// File: tb/sereep_wr_ctrl_tb.sv
module sereep_wr_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_drv, sda_drv, wc, mode;
  logic [2:0] strap;
  logic [6:0] peek_addr;
  logic [7:0] peek_data;
  logic       sda_oe;
  logic       sda_bus;
  int         total = 0;
  int         bad = 0;
  logic [7:0] expm [128];
  logic [7:0] txd  [16];

  localparam logic [7:0] DEV_OK = 8'hAA; // 1010, strap 101, write

  always #2 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  sereep_wr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .wc_i(wc),
    .burst_mode_i(mode), .strap_i(strap), .sda_oe_o(sda_oe),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic hp();
    repeat (4) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; hp(); scl_drv = 1'b1; hp();
    sda_drv = 1'b0; hp(); scl_drv = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; hp(); scl_drv = 1'b1; hp(); sda_drv = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; hp(); scl_drv = 1'b1; hp(); scl_drv = 1'b0;
    end
    sda_drv = 1'b1; hp(); scl_drv = 1'b1;
    repeat (2) @(negedge clk);
    ack = sda_oe;
    repeat (2) @(negedge clk);
    scl_drv = 1'b0; hp();
  endtask

  task automatic mem_cmp(input string req);
    for (int a = 0; a < 128; a++) begin
      peek_addr = 7'(a);
      @(negedge clk);
      chk(req, $sformatf("mem[%0h]", a), int'(peek_data), int'(expm[a]));
    end
  endtask

  // Full write transfer; acknowledges and the memory model follow R1..R7.
  task automatic xfer(input string req, input logic [7:0] dev, input logic [7:0] adr,
                      input int n, input logic md, input logic wcd, input logic wca,
                      input logic wcdat, input logic do_stop);
    logic ack;
    logic sel_ok, prot;
    logic [6:0] a;
    mode = md;
    wc = wcd;
    i2c_start();
    sel_ok = (dev == DEV_OK);
    send_byte(dev, ack);
    chk(req, "select ack", int'(ack), int'(sel_ok));
    wc = wca;
    send_byte(adr, ack);
    chk(req, "address ack", int'(ack), int'(sel_ok));
    prot = wcd | wca;
    wc = wcdat;
    for (int k = 0; k < n; k++) begin
      logic exp_ack;
      send_byte(txd[k], ack);
      exp_ack = sel_ok && !prot && (!md || k < 4);
      chk(req, $sformatf("data%0d ack", k), int'(ack), int'(exp_ack));
      if (exp_ack && do_stop) begin
        if (md) a = adr[6:0] + 7'(k);
        else    a = {adr[6:3], 3'(adr[2:0] + 3'(k))};
        expm[a] = txd[k];
      end
    end
    wc = 1'b0;
    if (do_stop) i2c_stop();
    chk("R8", "oe idle after transfer", int'(sda_oe), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1; wc = 1'b0; mode = 1'b0;
    strap = 3'b101; peek_addr = '0;
    for (int a = 0; a < 128; a++) expm[a] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state
    chk("R9", "oe after reset", int'(sda_oe), 0);
    mem_cmp("R9");

    // R1: strap sweep, only the strapped address answers
    for (int s = 0; s < 8; s++) begin
      i2c_start();
      send_byte({4'b1010, 3'(s), 1'b0}, ack);
      chk("R1", $sformatf("strap %0d", s), int'(ack), int'(s == 5));
      i2c_stop();
    end
    i2c_start(); send_byte(8'hAB, ack); chk("R1", "read select", int'(ack), 0); i2c_stop();
    i2c_start(); send_byte(8'h2A, ack); chk("R1", "wrong type", int'(ack), 0); i2c_stop();
    // R1: after a refusal, later bytes get no acknowledge
    txd[0] = 8'h77;
    xfer("R1", 8'hA2, 8'h10, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    mem_cmp("R1");

    // R2 / R4: byte writes, address bit 7 ignored, both modes
    txd[0] = 8'h3C;
    xfer("R2", DEV_OK, 8'h85, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    txd[0] = 8'hC3;
    xfer("R4", DEV_OK, 8'h40, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    txd[0] = 8'h5A;
    xfer("R4", DEV_OK, 8'hC1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    mem_cmp("R4");

    // R3: protection window
    for (int k = 0; k < 3; k++) txd[k] = 8'hE0 + 8'(k);
    xfer("R3", DEV_OK, 8'h20, 3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    xfer("R3", DEV_OK, 8'h28, 3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    mem_cmp("R3");
    xfer("R3", DEV_OK, 8'h30, 3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    mem_cmp("R3");

    // R5: multibyte wrap at the top of the array, cap at four
    for (int k = 0; k < 6; k++) txd[k] = 8'h90 + 8'(k);
    xfer("R5", DEV_OK, 8'h7E, 6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    mem_cmp("R5");

    // R6: page wrap with overwrite
    for (int k = 0; k < 10; k++) txd[k] = 8'h40 + 8'(k * 3);
    xfer("R6", DEV_OK, 8'h13, 10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    mem_cmp("R6");

    // R7: staged bytes invisible before STOP, dropped on repeated START
    for (int k = 0; k < 3; k++) txd[k] = 8'h11 * 8'(k + 1);
    xfer("R7", DEV_OK, 8'h50, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    mem_cmp("R7");
    i2c_start();
    send_byte(DEV_OK, ack);
    chk("R7", "select after restart", int'(ack), 1);
    i2c_stop();
    mem_cmp("R7");
    xfer("R7", DEV_OK, 8'h60, 3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    i2c_start();
    i2c_stop();
    mem_cmp("R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule